// File: doc/BRIEF.md
# Keyed Watchdog Timer with Software Reset Trigger

This block is a register-mapped watchdog. Once enabled it counts a loaded value down by one on each qualified `tick` pulse. When the count runs out it records a timeout in a status bit and reloads itself. If reset-on-timeout is enabled, it also raises `rst_req` for exactly one clock. Software keeps the system alive by writing a fixed restart key, which reloads the counter before it runs out.

A separate software-reset register lets firmware ask for an immediate system reset. The request is honoured only when two conditions hold: the control register's two-bit reset-mode field selects whole-chip reset, and the exact 32-bit enable key is written. Any other value, or any other mode, leaves the output quiet.

Two reset-mask registers exist in the map so that drivers can write them. Those writes have no effect. Reads return registered data one cycle after `rd_en`.

Top module: `wdk_top`

## Requirements
- R1: After reset the count reads 0, the status reads 0, the control reads 0, the reload register reads the `RST_RELOAD` parameter and `rst_req` is low.
- R2: While control bit 0 (enable) is set, each cycle with `tick` high lowers the count by one. With enable clear, `tick` leaves the count unchanged.
- R3: With a reload value N of at least 1, the N-th tick after a load is the timeout. On the timeout the count reloads from the reload register (offset 0x04) and status bit 0 (offset 0x10) becomes 1. If control bit 1 (reset-on-timeout) is set, `rst_req` is high for exactly the one cycle after that tick edge; otherwise it stays low.
- R4: Writing exactly 0x00004755 to offset 0x08 reloads the count from the reload register, taking priority over a tick in the same cycle. Any other value written there leaves the count unchanged.
- R5: Any write to offset 0x14 clears status bit 0. A timeout in the same cycle wins, and the bit stays 1.
- R6: Writing exactly 0xAEEDF123 to offset 0x20 while control bits [6:5] equal 2'b01 raises `rst_req` for exactly one cycle after the write edge, whether or not the timer is enabled.
- R7: A write to offset 0x20 with any other value, or while control bits [6:5] are not 2'b01, does not raise `rst_req`.
- R8: Writes to the mask registers at offsets 0x18 and 0x1C are accepted and change nothing; both read 0.
- R9: Writes to offsets outside the map, and to the read-only count (0x00) and status (0x10) registers, change no state; reads of undefined or write-only offsets return 0.
- R10: Read data appears on `rdata` one cycle after `rd_en`. The control register at 0x0C reads back only bit 0, bit 1 and bits [6:5]; all other bits read 0.
- R11: A control write that sets enable while the timer is disabled loads the count from the reload register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-down qualifier pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench sweeps the reload value from 1 to 6. For each value it checks every intermediate count, and it checks that the timeout lands on exactly the N-th tick; a design off by one in the expiry compare would fire a tick early or late.

It crosses all four reset modes with the correct key and two wrong keys. A design that ignores the mode field, or compares only part of the key, would raise a stray reset request.

The bench also drives a restart key and a tick in the same cycle, and a timeout together with a status clear, to catch wrong priorities. Writes to the mask registers, to unmapped offsets and to read-only registers are followed by read-back of all state, so that a decode that aliases those writes onto real registers is exposed.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_COUNT   = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_RELOAD  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_RESTART = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_CLEAR   = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_HWMASK  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_SWMASK  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_SWRST   = 6'h20;

    localparam logic [DATA_W-1:0] KICK_KEY  = 32'h0000_4755;
    localparam logic [DATA_W-1:0] SWRST_KEY = 32'hAEED_F123;
    localparam logic [1:0]        MODE_SOC  = 2'b01;

    typedef struct packed {
        logic [1:0] mode;
        logic       rst_on_to;
        logic       en;
    } ctrl_t;

    typedef struct packed {
        logic reload;
        logic restart;
        logic ctrl;
        logic clear;
        logic swrst;
    } wstb_t;
endpackage

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            // a restart or enable edge takes priority over a tick
            st_d.count = reload;
        end else if (en && tick) begin
            if (st_q.count <= ONE) begin
                expire     = 1'b1;
                st_d.count = reload;
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick && !load && count > ONE) |=> count == $past(count) - ONE);
    assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(count));
    assert_expire_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> count == $past(reload));
endmodule

// File: rtl/wdk_regfile.sv
module wdk_regfile
    import wdk_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int unsigned RST_RELOAD = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              status,
    output logic [DATA_W-1:0] rdata,
    output logic              load_req,
    output logic              swrst_hit
);
    localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(RST_RELOAD);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CNT_W-1:0]  reload;
        logic              status;
        logic [DATA_W-1:0] rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    wstb_t   stb;
    logic [DATA_W-1:0] rd_mux;
    logic    kick_hit;

    // write decode; the mask offsets and read-only offsets fall to no strobe
    always_comb begin
        stb = '0;
        if (wr_en) begin
            unique case (addr)
                OFF_RELOAD:  stb.reload  = 1'b1;
                OFF_RESTART: stb.restart = 1'b1;
                OFF_CTRL:    stb.ctrl    = 1'b1;
                OFF_CLEAR:   stb.clear   = 1'b1;
                OFF_SWRST:   stb.swrst   = 1'b1;
                default:     stb         = '0;
            endcase
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            OFF_COUNT:  rd_mux = DATA_W'(count);
            OFF_RELOAD: rd_mux = DATA_W'(st_q.reload);
            OFF_CTRL:   rd_mux = {25'b0, st_q.ctrl.mode, 3'b0,
                                  st_q.ctrl.rst_on_to, st_q.ctrl.en};
            OFF_STATUS: rd_mux = {31'b0, st_q.status};
            default:    rd_mux = '0;
        endcase
    end

    assign kick_hit  = stb.restart && (wdata == KICK_KEY);
    assign load_req  = kick_hit || (stb.ctrl && wdata[0] && !st_q.ctrl.en);
    assign swrst_hit = stb.swrst && (wdata == SWRST_KEY) &&
                       (st_q.ctrl.mode == MODE_SOC);

    always_comb begin
        st_d = st_q;
        if (stb.reload) st_d.reload = wdata[CNT_W-1:0];
        if (stb.ctrl) begin
            st_d.ctrl.mode      = wdata[6:5];
            st_d.ctrl.rst_on_to = wdata[1];
            st_d.ctrl.en        = wdata[0];
        end
        if (expire)         st_d.status = 1'b1;
        else if (stb.clear) st_d.status = 1'b0;
        if (rd_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.reload <= RELOAD_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl   = st_q.ctrl;
    assign reload = st_q.reload;
    assign status = st_q.status;
    assign rdata  = st_q.rdata;

    assert_status_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status);
    assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CLEAR && !expire) |=> !status);
    assert_ctrl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFF_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/wdk_rstgen.sv
module wdk_rstgen (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic rst_on_to,
    input  logic swrst_hit,
    output logic rst_req
);
    typedef struct packed {
        logic req;
    } req_st_t;

    req_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = (expire && rst_on_to) || swrst_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.req;

    assert_quiet_without_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!expire && !swrst_hit) |=> !rst_req);
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int          CNT_W      = 32,
    parameter int unsigned RST_RELOAD = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [5:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        rst_req
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             status;
    logic             load_req;
    logic             swrst_hit;
    logic             cnt_expire;

    wdk_regfile #(.CNT_W(CNT_W), .RST_RELOAD(RST_RELOAD)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .expire   (cnt_expire),
        .count    (count),
        .ctrl     (ctrl),
        .reload   (reload),
        .status   (status),
        .rdata    (rdata),
        .load_req (load_req),
        .swrst_hit(swrst_hit)
    );

    wdk_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .en    (ctrl.en),
        .load  (load_req),
        .reload(reload),
        .count (count),
        .expire(cnt_expire)
    );

    wdk_rstgen rst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (cnt_expire),
        .rst_on_to(ctrl.rst_on_to),
        .swrst_hit(swrst_hit),
        .rst_req  (rst_req)
    );

    assert_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(cnt_expire) || $past(wr_en && addr == OFF_SWRST)));
    assert_wrong_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SWRST && ctrl.mode != MODE_SOC && !cnt_expire)
        |=> !rst_req);
    assert_key_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_SWRST && wdata == SWRST_KEY && ctrl.mode == MODE_SOC)
        |=> rst_req);
    assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_RESTART && wdata == KICK_KEY) |=> count == $past(reload));
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_expire && !(wr_en && addr == OFF_CLEAR)) |=> $stable(status));
endmodule

// File: tb/wdk_top_tb_top.sv
module wdk_top_tb_top;
    localparam int          CNT_W   = 16;
    localparam int unsigned RST_VAL = 100;

    localparam logic [5:0] A_COUNT = 6'h00, A_RELOAD = 6'h04, A_RESTART = 6'h08,
                           A_CTRL = 6'h0C, A_STATUS = 6'h10, A_CLEAR = 6'h14,
                           A_HMASK = 6'h18, A_SMASK = 6'h1C, A_SWRST = 6'h20;
    localparam logic [31:0] KICK = 32'h0000_4755, SKEY = 32'hAEED_F123;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_req;

    int checks = 0;
    int fails = 0;
    int pulse_cnt = 0;

    always #5 clk = ~clk;

    wdk_top #(.CNT_W(CNT_W), .RST_RELOAD(RST_VAL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_n && rst_req) pulse_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic tk = 1'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; tick = tk;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    task automatic tk1();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rst_req", {31'b0, rst_req}, 0);
        rd(A_COUNT, v);  chk("R1 count", v, 0);
        rd(A_STATUS, v); chk("R1 status", v, 0);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_RELOAD, v); chk("R1 reload", v, RST_VAL);

        // R2 ticks while disabled do nothing
        repeat (3) tk1();
        rd(A_COUNT, v);  chk("R2 disabled count", v, 0);
        rd(A_STATUS, v); chk("R2 disabled status", v, 0);

        // R2/R3/R11 sweep of reload values with reset-on-timeout
        for (int n = 1; n <= 6; n++) begin
            wr(A_RELOAD, n);
            wr(A_CTRL, 32'h3);
            rd(A_COUNT, v); chk("R11 load on enable", v, n);
            for (int k = 1; k < n; k++) begin
                tk1();
                rd(A_COUNT, v); chk("R2 countdown", v, n - k);
                chk("R3 no early pulse", {31'b0, rst_req}, 0);
            end
            tk1();
            chk("R3 pulse on timeout", {31'b0, rst_req}, 1);
            @(negedge clk);
            chk("R3 pulse one cycle", {31'b0, rst_req}, 0);
            rd(A_STATUS, v); chk("R3 status set", v, 1);
            rd(A_COUNT, v);  chk("R3 reload after timeout", v, n);
            wr(A_CLEAR, 32'h1234_0000 + n);
            rd(A_STATUS, v); chk("R5 clear", v, 0);
            wr(A_CTRL, 32'h0);
        end

        // R3 timeout without reset-on-timeout: status only
        p0 = pulse_cnt;
        wr(A_RELOAD, 2);
        wr(A_CTRL, 32'h1);
        tk1(); tk1();
        chk("R3 no pulse when disabled", {31'b0, rst_req}, 0);
        rd(A_STATUS, v); chk("R3 status without pulse", v, 1);
        chk("R3 pulse count", pulse_cnt - p0, 0);
        wr(A_CLEAR, 0);
        wr(A_CTRL, 32'h0);

        // R4 restart key
        wr(A_RELOAD, 5);
        wr(A_CTRL, 32'h1);
        repeat (3) tk1();
        rd(A_COUNT, v); chk("R4 before kick", v, 2);
        foreach (v[i]) if (i < 5) begin
            logic [31:0] bad;
            bad = (i == 0) ? 32'h4754 : (i == 1) ? 32'h4756 : (i == 2) ? 32'h0001_4755 :
                  (i == 3) ? SKEY : 32'h0;
            wr(A_RESTART, bad);
            rd(A_COUNT, v); chk("R4 wrong key ignored", v, 2);
        end
        wr(A_RESTART, KICK);
        rd(A_COUNT, v); chk("R4 kick reload", v, 5);
        tk1();
        wr(A_RESTART, KICK, 1'b1);
        rd(A_COUNT, v); chk("R4 kick beats tick", v, 5);
        wr(A_CTRL, 32'h0);

        // R5 timeout and clear in the same cycle
        wr(A_RELOAD, 1);
        wr(A_CTRL, 32'h1);
        wr(A_CLEAR, 32'hFFFF_FFFF, 1'b1);
        rd(A_STATUS, v); chk("R5 timeout wins over clear", v, 1);
        wr(A_CLEAR, 0);
        rd(A_STATUS, v); chk("R5 clear after", v, 0);
        wr(A_CTRL, 32'h0);

        // R6/R7 mode x key sweep
        for (int m = 0; m < 4; m++) begin
            for (int kk = 0; kk < 3; kk++) begin
                logic [31:0] key;
                logic exp;
                key = (kk == 0) ? SKEY : (kk == 1) ? (SKEY ^ 32'h8000_0000) : 32'h0000_F123;
                exp = (m == 1) && (kk == 0);
                wr(A_CTRL, 32'(m) << 5);
                wr(A_SWRST, key);
                if (exp) chk("R6 software reset pulse", {31'b0, rst_req}, 1);
                else     chk("R7 software reset blocked", {31'b0, rst_req}, 0);
                @(negedge clk);
                chk("R6 software pulse one cycle", {31'b0, rst_req}, 0);
            end
        end
        rd(A_CTRL, v); chk("R10 mode readback", v, 32'h60);
        wr(A_CTRL, 32'h0);

        // R8 mask registers
        wr(A_RELOAD, 9);
        wr(A_HMASK, 32'hFFFF_FFFF);
        wr(A_SMASK, 32'hFFFF_FFFF);
        rd(A_HMASK, v);  chk("R8 hw mask reads 0", v, 0);
        rd(A_SMASK, v);  chk("R8 sw mask reads 0", v, 0);
        rd(A_CTRL, v);   chk("R8 ctrl untouched", v, 0);
        rd(A_RELOAD, v); chk("R8 reload untouched", v, 9);
        rd(A_STATUS, v); chk("R8 status untouched", v, 0);

        // R9 undefined offsets and read-only registers
        rd(A_COUNT, v);
        p0 = int'(v);
        for (int a = 6'h21; a < 64; a++) begin
            wr(6'(a), 32'hFFFF_FFFF);
            rd(6'(a), v);
            if (a % 4 == 0) chk("R9 undefined reads 0", v, 0);
        end
        wr(A_COUNT, 32'h0000_0077);
        wr(A_STATUS, 32'hFFFF_FFFF);
        rd(A_COUNT, v);  chk("R9 count read-only", v, 32'(p0));
        rd(A_STATUS, v); chk("R9 status read-only", v, 0);
        rd(A_RELOAD, v); chk("R9 reload untouched", v, 9);
        rd(A_CTRL, v);   chk("R9 ctrl untouched", v, 0);
        rd(A_RESTART, v); chk("R9 restart reads 0", v, 0);
        chk("R9 no pulse", {31'b0, rst_req}, 0);

        // R10 control readback mask
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, v); chk("R10 ctrl mask", v, 32'h63);
        wr(A_CTRL, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule